// File: doc/BRIEF.md
# Host IN Transaction Retry Controller

This block sequences a single bulk, control or interrupt IN transaction on the host side of a serial bus. A scheduler starts a command and supplies the data toggle it expects. The controller then asks the packet transmitter for an IN token and waits for the receiver to report either a response packet or an expired inter-packet gap. It sorts the outcome into one of five classes. These are accepted data, a repeated packet (the device retransmitted data the host already has), busy, stalled, and transmission error. It then raises the matching handshake and data-accept strobes and returns a one-cycle result: advance to the next command, issue the same command again, or halt the pipe.

Transmission errors are counted across the retries of one command. The count is kept in a small saturating-to-halt counter. The third strike turns a retry into a halt. A busy reply or a repeated packet leaves the count as it is. The scheduler marks the first attempt of each new command so that the count starts again from zero.

Top module: `hin_retry_ctrl`

## Requirements
- R1: A `cmd_start` taken while idle produces a `tok_req` pulse of exactly one cycle in the following cycle. The value of `cmd_toggle` is captured as the expected sequence bit.
- R2: A response with `rsp_kind`=2'b00 (data), good CRC and `rsp_seq` equal to the captured toggle gives `done` with `result`=2'b00 (next). `data_accept` and `ack_req` pulse in that same cycle, and the error count is cleared.
- R3: A data response with good CRC but a sequence bit different from the captured toggle raises `ack_req` without `data_accept` and gives `result`=2'b01 (same). The error count is unchanged.
- R4: A response with `rsp_kind`=2'b01 (busy) gives `result`=2'b01 with no handshake and no accept. The error count is unchanged.
- R5: A response with `rsp_kind`=2'b10 (stall) gives `result`=2'b10 (halt) with no handshake and no accept, and clears the error count.
- R6: Three events raise the error count: a `rsp_timeout` without `rsp_valid`, a data response with bad CRC, and `rsp_kind`=2'b11 (unexpected). With MAX_ERR=3, the first two such errors give `result`=2'b01 and the third gives 2'b10 and clears the count. None of these events raises `ack_req` or `data_accept`.
- R7: The error count persists across starts with `cmd_first`=0. A start with `cmd_first`=1 clears it.
- R8: When `rsp_valid` and `rsp_timeout` are both high in the same cycle, the packet is classified and the timeout is ignored.
- R9: `done` rises exactly one cycle after the edge that samples the response and lasts one cycle. `result` reads 2'b00 whenever `done` is low.
- R10: A `cmd_start` while waiting for a response is ignored, so no second token is requested. `rsp_valid` or `rsp_timeout` while idle produces no `done`.
- R11: During and directly after reset all outputs are low and the controller is idle with a zero error count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start one IN attempt |
| cmd_first | input | 1 | Attempt is the first of a new command (clears error count) |
| cmd_toggle | input | 1 | Expected data sequence bit |
| tok_req | output | 1 | Request to send an IN token |
| rsp_valid | input | 1 | Response packet received |
| rsp_kind | input | 2 | Response type: 00 data, 01 busy, 10 stall, 11 other |
| rsp_seq | input | 1 | Sequence bit of a data response |
| rsp_crc_ok | input | 1 | Data response CRC is good |
| rsp_timeout | input | 1 | Inter-packet wait expired |
| ack_req | output | 1 | Request to send an ACK handshake |
| data_accept | output | 1 | Received data is accepted (receiver toggle may advance) |
| done | output | 1 | Result valid pulse |
| result | output | 2 | 00 next, 01 same, 10 halt |

## Verification
On every cycle, the assertions check the following: a token follows each idle start, accepted data is always ACKed and reported as next, a halt never carries a handshake, and `done` is a single-cycle pulse. They also check that a start while waiting yields no token and that the error count stays bounded and clears when required. Other behaviour needs the bench's scenarios, driven against a behavioural reference model. This covers how the count carries over several retries, where NAKs and repeated packets are mixed in without changing it. It also covers the exact attempt on which the third strike turns into a halt, the clear on a first attempt, and the priority of a packet over a simultaneous timeout.

// File: rtl/hin_pkg.sv
package hin_pkg;

  typedef enum logic [1:0] {
    RES_NEXT = 2'b00,
    RES_SAME = 2'b01,
    RES_HALT = 2'b10
  } res_e;

  typedef enum logic [1:0] {
    KIND_DATA  = 2'b00,
    KIND_BUSY  = 2'b01,
    KIND_STALL = 2'b10,
    KIND_OTHER = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    CL_NONE  = 3'd0,
    CL_GOOD  = 3'd1,
    CL_DUP   = 3'd2,
    CL_BUSY  = 3'd3,
    CL_STALL = 3'd4,
    CL_ERR   = 3'd5
  } cls_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;

endpackage

// File: rtl/hin_classify.sv
module hin_classify
  import hin_pkg::*;
(
  input  logic       evt_pkt,
  input  logic       evt_tmo,
  input  logic [1:0] kind,
  input  logic       seq,
  input  logic       crc_ok,
  input  logic       exp_tog,
  output cls_e       cls
);

  always_comb begin
    cls = CL_NONE;
    if (evt_pkt) begin
      unique case (kind)
        KIND_DATA: begin
          if (!crc_ok)            cls = CL_ERR;
          else if (seq == exp_tog) cls = CL_GOOD;
          else                    cls = CL_DUP;
        end
        KIND_BUSY:  cls = CL_BUSY;
        KIND_STALL: cls = CL_STALL;
        default:    cls = CL_ERR;
      endcase
    end else if (evt_tmo) begin
      cls = CL_ERR;
    end
  end

endmodule

// File: rtl/hin_err_ctr.sv
module hin_err_ctr #(
  parameter int MAX_ERR = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);

  localparam int CW = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_ERR - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == LAST);

  AST_ERR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R7

  AST_NO_INC_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !at_limit); // R6

endmodule

// File: rtl/hin_seq.sv
module hin_seq
  import hin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_first,
  input  logic       cmd_toggle,
  input  cls_e       cls,
  input  logic       at_limit,
  output logic       exp_tog,
  output logic       err_inc,
  output logic       err_clr,
  output logic       tok_req,
  output logic       ack_req,
  output logic       data_accept,
  output logic       done,
  output logic [1:0] result
);

  st_e  st_q, st_d;
  logic tog_q, tog_d, tog_en;
  logic tok_q, tok_d, ack_q, ack_d, acc_q, acc_d, done_q, done_d;
  res_e res_q, res_d;

  always_comb begin
    st_d    = st_q;
    tog_d   = tog_q;
    tog_en  = 1'b0;
    tok_d   = 1'b0;
    ack_d   = 1'b0;
    acc_d   = 1'b0;
    done_d  = 1'b0;
    res_d   = RES_NEXT;
    err_inc = 1'b0;
    err_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_start) begin
          st_d    = ST_WAIT;
          tog_d   = cmd_toggle;
          tog_en  = 1'b1;
          tok_d   = 1'b1;
          err_clr = cmd_first;
        end
      end
      ST_WAIT: begin
        if (cls != CL_NONE) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          unique case (cls)
            CL_GOOD: begin
              ack_d = 1'b1; acc_d = 1'b1; res_d = RES_NEXT; err_clr = 1'b1;
            end
            CL_DUP: begin
              ack_d = 1'b1; res_d = RES_SAME;
            end
            CL_BUSY: res_d = RES_SAME;
            CL_STALL: begin
              res_d = RES_HALT; err_clr = 1'b1;
            end
            CL_ERR: begin
              if (at_limit) begin
                res_d = RES_HALT; err_clr = 1'b1;
              end else begin
                res_d = RES_SAME; err_inc = 1'b1;
              end
            end
            default: res_d = RES_NEXT;
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tok_q  <= 1'b0;
      ack_q  <= 1'b0;
      acc_q  <= 1'b0;
      done_q <= 1'b0;
      res_q  <= RES_NEXT;
    end else begin
      st_q   <= st_d;
      tok_q  <= tok_d;
      ack_q  <= ack_d;
      acc_q  <= acc_d;
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

  assign exp_tog     = tog_q;
  assign tok_req     = tok_q;
  assign ack_req     = ack_q;
  assign data_accept = acc_q;
  assign done        = done_q;
  assign result      = res_q;

  AST_TOKEN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cmd_start) |=> tok_q); // R1

  AST_ACCEPT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> (ack_q && done_q && res_q == RES_NEXT)); // R2

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && res_q == RES_HALT) |-> (!ack_q && !acc_q)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9

  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> (res_q == RES_NEXT && !ack_q)); // R9

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && cmd_start) |=> !tok_q); // R10

endmodule

// File: rtl/hin_retry_ctrl.sv
module hin_retry_ctrl
  import hin_pkg::*;
#(
  parameter int MAX_ERR = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_first,
  input  logic       cmd_toggle,
  output logic       tok_req,
  input  logic       rsp_valid,
  input  logic [1:0] rsp_kind,
  input  logic       rsp_seq,
  input  logic       rsp_crc_ok,
  input  logic       rsp_timeout,
  output logic       ack_req,
  output logic       data_accept,
  output logic       done,
  output logic [1:0] result
);

  cls_e cls;
  logic exp_tog, err_inc, err_clr, at_limit;

  hin_classify u_cls (
    .evt_pkt (rsp_valid),
    .evt_tmo (rsp_timeout),
    .kind    (rsp_kind),
    .seq     (rsp_seq),
    .crc_ok  (rsp_crc_ok),
    .exp_tog (exp_tog),
    .cls     (cls)
  );

  hin_err_ctr #(.MAX_ERR(MAX_ERR)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (err_clr),
    .inc      (err_inc),
    .at_limit (at_limit)
  );

  hin_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .cmd_first   (cmd_first),
    .cmd_toggle  (cmd_toggle),
    .cls         (cls),
    .at_limit    (at_limit),
    .exp_tog     (exp_tog),
    .err_inc     (err_inc),
    .err_clr     (err_clr),
    .tok_req     (tok_req),
    .ack_req     (ack_req),
    .data_accept (data_accept),
    .done        (done),
    .result      (result)
  );

endmodule

// File: tb/hin_retry_ctrl_tb_top.sv
`timescale 1ns/100ps
module hin_retry_ctrl_tb_top;

  localparam int MAXE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, cmd_first = 0, cmd_toggle = 0;
  logic rsp_valid = 0, rsp_seq = 0, rsp_crc_ok = 0, rsp_timeout = 0;
  logic [1:0] rsp_kind = 0;
  logic tok_req, ack_req, data_accept, done;
  logic [1:0] result;

  always #2.5 clk = ~clk;

  hin_retry_ctrl #(.MAX_ERR(MAXE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_first(cmd_first),
    .cmd_toggle(cmd_toggle), .tok_req(tok_req), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .rsp_seq(rsp_seq), .rsp_crc_ok(rsp_crc_ok),
    .rsp_timeout(rsp_timeout), .ack_req(ack_req), .data_accept(data_accept),
    .done(done), .result(result)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit ended = 0;

  // behavioural reference model
  bit m_busy, m_tog, m_tok, m_ack, m_acc, m_done;
  int m_err;
  int m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_tog = 0; m_err = 0;
      m_tok = 0; m_ack = 0; m_acc = 0; m_done = 0; m_res = 0;
    end else begin
      m_tok = 0; m_ack = 0; m_acc = 0; m_done = 0; m_res = 0;
      if (!m_busy) begin
        if (cmd_start) begin
          m_busy = 1; m_tok = 1; m_tog = cmd_toggle;
          if (cmd_first) m_err = 0;
        end
      end else if (rsp_valid || rsp_timeout) begin
        bit is_err;
        is_err = 0;
        m_busy = 0; m_done = 1;
        if (rsp_valid) begin
          if (rsp_kind == 2'b00 && rsp_crc_ok && rsp_seq == m_tog) begin
            m_ack = 1; m_acc = 1; m_res = 0; m_err = 0;
          end else if (rsp_kind == 2'b00 && rsp_crc_ok) begin
            m_ack = 1; m_res = 1;
          end else if (rsp_kind == 2'b01) begin
            m_res = 1;
          end else if (rsp_kind == 2'b10) begin
            m_res = 2; m_err = 0;
          end else begin
            is_err = 1;
          end
        end else begin
          is_err = 1;
        end
        if (is_err) begin
          m_err = m_err + 1;
          if (m_err >= MAXE) begin m_res = 2; m_err = 0; end
          else m_res = 1;
        end
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(int'(tok_req), int'(m_tok), "R1/R10 tok_req");
      chk(int'(data_accept), int'(m_acc), "R2 data_accept");
      chk(int'(ack_req), int'(m_ack), "R3/R4/R6 ack_req");
      chk(int'(done), int'(m_done), "R9/R10 done");
      chk(int'(result), m_res, "R6/R9 result");
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !ended) begin
      errors++;
      $display("FAIL R9 watchdog: actual no completion expected completion by cycle 20000");
      finish_run();
    end
  end

  // one attempt: start, optional busy poke, response, check result
  task automatic txn(input bit first, input bit tog, input bit pkt, input bit [1:0] kind,
                     input bit seq, input bit crc, input bit tmo, input bit poke,
                     input int exp_res, input string tag);
    @(negedge clk);
    cmd_start = 1; cmd_first = first; cmd_toggle = tog;
    @(negedge clk);
    cmd_start = 0; cmd_first = 0;
    chk(int'(tok_req), 1, {tag, " token"});
    if (poke) begin
      cmd_start = 1; cmd_first = 1; cmd_toggle = ~tog;   // R10: ignored while waiting
      @(negedge clk);
      cmd_start = 0; cmd_first = 0;
      chk(int'(tok_req), 0, "R10 no second token");
    end
    @(negedge clk);
    rsp_valid = pkt; rsp_kind = kind; rsp_seq = seq; rsp_crc_ok = crc; rsp_timeout = tmo;
    @(negedge clk);
    rsp_valid = 0; rsp_timeout = 0; rsp_kind = 0; rsp_seq = 0; rsp_crc_ok = 0;
    chk(int'(done), 1, {tag, " done"});
    chk(int'(result), exp_res, {tag, " result"});
    @(negedge clk);
    chk(int'(done), 0, "R9 single-cycle done");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs quiet during reset
    chk(int'(tok_req | ack_req | data_accept | done), 0, "R11 reset outputs");
    chk(int'(result), 0, "R11 reset result");
    rst_n = 1;
    @(negedge clk);
    chk(int'(done | tok_req), 0, "R11 after reset");

    // R2: accepted data, both toggles
    txn(1, 0, 1, 2'b00, 0, 1, 0, 0, 0, "R2 good seq0");
    txn(1, 1, 1, 2'b00, 1, 1, 0, 0, 0, "R2 good seq1");
    // R3: repeated packet
    txn(1, 0, 1, 2'b00, 1, 1, 0, 0, 1, "R3 toggle mismatch");
    // R4: busy
    txn(1, 1, 1, 2'b01, 0, 0, 0, 0, 1, "R4 busy");
    // R5: stall
    txn(1, 0, 1, 2'b10, 0, 1, 0, 0, 2, "R5 stall");
    // R6/R7: errors persist across busy and mismatch retries
    txn(1, 0, 0, 2'b00, 0, 0, 1, 0, 1, "R6 timeout strike1");
    txn(0, 0, 1, 2'b01, 0, 0, 0, 0, 1, "R4 busy keeps count");
    txn(0, 0, 1, 2'b00, 0, 0, 0, 0, 1, "R6 bad crc strike2");
    txn(0, 0, 1, 2'b00, 1, 1, 0, 0, 1, "R3 mismatch keeps count");
    txn(0, 0, 1, 2'b11, 0, 1, 0, 0, 2, "R6 unexpected strike3 halt");
    // after halt the count restarts even without first
    txn(0, 0, 0, 2'b00, 0, 0, 1, 0, 1, "R6 count cleared by halt");
    // R7: first attempt clears a pending count
    txn(0, 0, 0, 2'b00, 0, 0, 1, 0, 1, "R7 strike2 pending");
    txn(1, 0, 0, 2'b00, 0, 0, 1, 0, 1, "R7 first clears");
    txn(0, 0, 0, 2'b00, 0, 0, 1, 0, 1, "R7 strike2 again");
    txn(0, 0, 0, 2'b00, 0, 0, 1, 0, 2, "R7 strike3 halt");
    // good data clears count
    txn(1, 1, 0, 2'b00, 0, 0, 1, 0, 1, "R6 strike1");
    txn(0, 1, 1, 2'b00, 1, 1, 0, 0, 0, "R2 good clears count");
    txn(0, 0, 0, 2'b00, 0, 0, 1, 0, 1, "R2 count zero after next");
    txn(0, 0, 0, 2'b00, 0, 0, 1, 0, 1, "R6 strike2");
    // R8: packet wins over timeout
    txn(0, 1, 1, 2'b00, 1, 1, 1, 0, 0, "R8 packet over timeout");
    // R10: start while waiting ignored, captured toggle unaffected
    txn(1, 1, 1, 2'b00, 1, 1, 0, 1, 0, "R10 busy start ignored");
    // R10: responses while idle ignored
    @(negedge clk);
    rsp_valid = 1; rsp_kind = 2'b00; rsp_crc_ok = 1; rsp_timeout = 1;
    @(negedge clk);
    rsp_valid = 0; rsp_timeout = 0; rsp_crc_ok = 0;
    chk(int'(done), 0, "R10 idle response ignored");
    chk(int'(ack_req | data_accept), 0, "R10 idle no handshake");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule